// File: doc/BRIEF.md
# Change-Only Sample Recorder

This block takes signed 16-bit samples, each marked by a one-cycle valid strobe, and keeps only those whose value differs from the sample stored last. Runs of identical values collapse into one stored entry, and a saturating counter records how many repeats were discarded. Storage is a set of 32-bit words, each holding two samples, with the lower-indexed sample in the low half. Recording stops when the buffer holds its fixed number of samples, which is 100 by default.

A clear strobe starts a sweep that zeroes the buffer one word per clock. The sweep also resets the fill count, the drop counter and the comparison reference, so a new run can be recorded while the rest of the system keeps running. A system reset starts the same sweep. A read port returns the sample at a requested index one clock later, and it also exposes the fill count, the full flag, the busy flag and the drop count.

Top module: `delta_capture`

## Requirements
- R1: After reset, `busy` is high for exactly 50 sampled cycles, counted from the cycle in which reset is released. During that time and after it, `fill_count` is 0, `full` is 0 and `drop_count` is 0.
- R2: The first accepted sample after a reset or a clear is always stored, including the value 0000h, and it becomes the comparison reference.
- R3: A later sample is stored only if it differs from the sample stored last. A sample equal to that value is not written and increments `drop_count`.
- R4: Stored samples are read back in arrival order. Index k returns the k-th stored 16-bit word unchanged, including 7FFFh and 8000h. `rd_data` reflects the `rd_idx` of the previous clock edge.
- R5: A read at an index equal to or greater than `fill_count` returns 0000h.
- R6: When `fill_count` reaches 100, `full` goes high. After that, valid samples change neither the count, the buffer contents nor `drop_count`.
- R7: A clear makes `busy` high for 50 cycles, sets `fill_count`, `drop_count` and `full` to 0, and zeroes the buffer. Samples that arrive while `busy` is high are ignored.
- R8: `drop_count` saturates at 255 and does not wrap.
- R9: A clear in the same cycle as a valid sample takes priority, and that sample is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Strobe: wipe the buffer and rearm recording |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Two's-complement sample |
| rd_idx | input | 7 | Sample index to read |
| rd_data | output | 16 | Sample at the index of the previous cycle, or 0 |
| fill_count | output | 7 | Number of samples stored in this run |
| full | output | 1 | Buffer holds 100 samples |
| busy | output | 1 | Clear sweep in progress |
| drop_count | output | 8 | Repeats discarded in this run, saturating |

## Verification
The bench targets four corner cases. The first is a leading 0000h right after a clear: a design that compared it against the zeroed reference would drop it. The second is a repeat arriving on the 101st sample: a design that let the drop counter or the buffer move while full would expose the change. The third is a clear that coincides with a valid sample: a design that gave the sample priority would start the run with a count of one. The fourth is a long run of repeats: a counter that wrapped would read a small value. The bench also checks the sweep length, that samples are blocked during the sweep, and that reads beyond the fill count return zero, because an unmasked read would return data left over from an earlier run.

// File: rtl/dcap_pkg.sv
// Package: shared sizing for the change-only sample recorder.
// Assumes the storage word is an integer multiple of the sample width.
package dcap_pkg;
    localparam int SMP_W  = 16;
    localparam int WORD_W = 32;
    localparam int DEPTH  = 100;
    localparam int DROP_W = 8;
endpackage

// File: rtl/dcap_sweep.sv
// Clear sweeper: on reset or clear, walks every storage word once,
// one per clock, raising busy for exactly WORDS cycles.
// Assumes the store zeroes the word at sweep_addr while busy is high.
module dcap_sweep #(
    parameter int WORDS = 50,
    localparam int WA_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic            busy,
    output logic [WA_W-1:0] sweep_addr
);
    localparam logic [WA_W-1:0] LAST = WA_W'(WORDS - 1);

    logic            busy_q;
    logic [WA_W-1:0] ptr_q;

    // Arm on reset/clear, step the pointer, and drop busy after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy_q <= 1'b1;
            ptr_q  <= '0;
        end else if (busy_q) begin
            if (ptr_q == LAST) begin
                busy_q <= 1'b0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign busy       = busy_q;
    assign sweep_addr = ptr_q;

    AST_SWEEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ptr_q <= LAST); // R7
    AST_SWEEP_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(ptr_q) == LAST); // R7
endmodule

// File: rtl/dcap_filter.sv
// Change filter: accepts a valid sample only when idle and not full,
// stores it if it is the first of the run or differs from the last stored
// value, and otherwise counts it as a dropped repeat (saturating).
// Assumes clear and reset restart the run.
module dcap_filter #(
    parameter int SMP_W  = 16,
    parameter int DEPTH  = 100,
    parameter int DROP_W = 8,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              busy,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  count,
    output logic              full,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [IDX_W-1:0]  LIMIT    = IDX_W'(DEPTH);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    logic [SMP_W-1:0]  ref_q;
    logic [IDX_W-1:0]  count_q;
    logic [DROP_W-1:0] drop_q;
    logic              full_c;
    logic              take;
    logic              differs;

    // Decide whether the current sample is taken, and whether it is new.
    always_comb begin
        full_c  = (count_q == LIMIT);
        take    = smp_valid && !busy && !clear && !full_c;
        differs = (count_q == '0) || (smp_data != ref_q);
        wr_en   = take && differs;
    end

    // Track the fill count, the comparison reference and the drop counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
            drop_q  <= '0;
            ref_q   <= '0;
        end else if (wr_en) begin
            count_q <= count_q + 1'b1;
            ref_q   <= smp_data;
        end else if (take && (drop_q != DROP_MAX)) begin
            drop_q <= drop_q + 1'b1;
        end
    end

    assign wr_idx     = count_q;
    assign count      = count_q;
    assign full       = full_c;
    assign drop_count = drop_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LIMIT); // R6
    AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (full_c && !clear) |=> ($stable(count_q) && $stable(drop_q))); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R3
    AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q == DROP_MAX && !clear) |=> drop_q == DROP_MAX); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0 && drop_q == '0)); // R9
endmodule

// File: rtl/dcap_store.sv
// Sample store: one memory per half-word lane, so a single sample can be
// written without touching its neighbour; the sweep zeroes all lanes of a
// word at once. The read is registered and masked to zero at or beyond
// the read limit (the current fill count).
// Assumes sweep writes and sample writes never coincide.
module dcap_store #(
    parameter int SMP_W  = 16,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 100,
    localparam int HALVES = WORD_W / SMP_W,
    localparam int WORDS  = (DEPTH + HALVES - 1) / HALVES,
    localparam int WA_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LN_W   = (HALVES > 1) ? $clog2(HALVES) : 1,
    localparam int IDX_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sweep_en,
    input  logic [WA_W-1:0]  sweep_addr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SMP_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rd_limit,
    output logic [SMP_W-1:0] rd_data
);
    logic [WA_W-1:0]              wr_word;
    logic [LN_W-1:0]              wr_lane;
    logic                         rd_hit;
    logic [WA_W-1:0]              rd_word;
    logic [LN_W-1:0]              rd_lane;
    logic [HALVES-1:0][SMP_W-1:0] lane_rd;
    logic [SMP_W-1:0]             rd_q;

    // Split write and read indices into word address and lane.
    always_comb begin
        wr_word = WA_W'(wr_idx / IDX_W'(HALVES));
        wr_lane = LN_W'(wr_idx % IDX_W'(HALVES));
        rd_hit  = (rd_idx < rd_limit);
        rd_word = rd_hit ? WA_W'(rd_idx / IDX_W'(HALVES)) : '0;
        rd_lane = LN_W'(rd_idx % IDX_W'(HALVES));
    end

    for (genvar g = 0; g < HALVES; g++) begin : g_lane
        logic [SMP_W-1:0] mem [WORDS];

        // Lane write: the sweep zeroes the word, otherwise take the sample.
        always_ff @(posedge clk) begin
            if (sweep_en) begin
                mem[sweep_addr] <= '0;
            end else if (wr_en && (wr_lane == LN_W'(g))) begin
                mem[wr_word] <= wr_data;
            end
        end

        assign lane_rd[g] = mem[rd_word];
    end

    // Registered, masked read of the selected lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_hit ? lane_rd[rd_lane] : '0;
        end
    end

    assign rd_data = rd_q;

    AST_NO_WRITE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |-> !wr_en); // R7
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IDX_W'(DEPTH)); // R6
    AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_limit == '0) |=> rd_data == '0); // R5
endmodule

// File: rtl/delta_capture.sv
// Top of the change-only sample recorder: wires the clear sweeper, the
// change filter and the lane store together. Assumes a single clock
// domain and one-cycle sample strobes.
module delta_capture #(
    parameter int SMP_W  = dcap_pkg::SMP_W,
    parameter int WORD_W = dcap_pkg::WORD_W,
    parameter int DEPTH  = dcap_pkg::DEPTH,
    parameter int DROP_W = dcap_pkg::DROP_W,
    localparam int HALVES = WORD_W / SMP_W,
    localparam int WORDS  = (DEPTH + HALVES - 1) / HALVES,
    localparam int WA_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IDX_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SMP_W-1:0]  rd_data,
    output logic [IDX_W-1:0]  fill_count,
    output logic              full,
    output logic              busy,
    output logic [DROP_W-1:0] drop_count
);
    logic            sweep_busy;
    logic [WA_W-1:0] sweep_addr;
    logic            wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] count;

    dcap_sweep #(.WORDS(WORDS)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .busy       (sweep_busy),
        .sweep_addr (sweep_addr)
    );

    dcap_filter #(.SMP_W(SMP_W), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .busy       (sweep_busy),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .count      (count),
        .full       (full),
        .drop_count (drop_count)
    );

    dcap_store #(.SMP_W(SMP_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .sweep_en   (sweep_busy),
        .sweep_addr (sweep_addr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (smp_data),
        .rd_idx     (rd_idx),
        .rd_limit   (count),
        .rd_data    (rd_data)
    );

    assign fill_count = count;
    assign busy       = sweep_busy;

    AST_BUSY_BLOCKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear) |=> fill_count == $past(fill_count)); // R7
endmodule

// File: tb/delta_capture_tb.sv
module delta_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {expect_stored, sample}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 16'h0000}, {1'b0, 16'h0000}, {1'b1, 16'h7FFF}, {1'b0, 16'h7FFF},
        {1'b1, 16'h8000}, {1'b0, 16'h8000}, {1'b0, 16'h8000}, {1'b1, 16'h0001},
        {1'b1, 16'hFFFF}, {1'b1, 16'h0001}, {1'b0, 16'h0001}, {1'b1, 16'h1234}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [6:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [6:0]  fill_count;
    logic        full;
    logic        busy;
    logic [7:0]  drop_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] exp_mem [NVEC];
    int exp_cnt = 0;
    int exp_drop = 0;

    delta_capture u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .smp_valid(smp_valid),
        .smp_data(smp_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .fill_count(fill_count), .full(full), .busy(busy), .drop_count(drop_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] d);
        smp_valid = 1'b1;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd(input int idx, output int val);
        rd_idx = 7'(idx);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_clear(output int n);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        wait_idle(n);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int n;
        int v;
        // R1: reset state and sweep length
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_idle(n);
        check("R1 busy cycles", n, 50);
        check("R1 count", int'(fill_count), 0);
        check("R1 full", int'(full), 0);
        check("R1 drops", int'(drop_count), 0);
        rd(0, v);
        check("R5 read empty", v, 0);

        // R2/R3: table-driven change filter
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][16]) begin
                exp_mem[exp_cnt] = VEC[i][15:0];
                exp_cnt++;
            end else begin
                exp_drop++;
            end
            send(VEC[i][15:0]);
            check(i == 0 ? "R2 first stored" : "R3 count", int'(fill_count), exp_cnt);
        end
        check("R3 drops", int'(drop_count), exp_drop);

        // R4: readback in order, one-cycle latency
        for (int j = 0; j < exp_cnt; j++) begin
            rd(j, v);
            check("R4 readback", v, int'(exp_mem[j]));
        end
        // R5: beyond the fill count
        rd(exp_cnt, v);
        check("R5 at count", v, 0);
        rd(127, v);
        check("R5 far index", v, 0);

        // R7: clear resets everything and blocks samples during the sweep
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        send(16'h0005);
        wait_idle(n);
        check("R7 busy cycles", n + 1, 50);
        check("R7 count", int'(fill_count), 0);
        check("R7 drops", int'(drop_count), 0);
        check("R7 full", int'(full), 0);
        rd(0, v);
        check("R7 read after clear", v, 0);

        // R9: clear beats a simultaneous sample
        clear = 1'b1;
        smp_valid = 1'b1;
        smp_data = 16'hAAAA;
        @(negedge clk);
        clear = 1'b0;
        smp_valid = 1'b0;
        wait_idle(n);
        check("R9 count", int'(fill_count), 0);
        send(16'h0000);
        check("R2 zero first after clear", int'(fill_count), 1);

        // R6: fill to the limit
        do_clear(n);
        for (int k = 0; k < 110; k++) send(16'(16'h0100 + k));
        check("R6 count", int'(fill_count), 100);
        check("R6 full", int'(full), 1);
        send(16'h0163);
        check("R6 drops frozen", int'(drop_count), 0);
        check("R6 count frozen", int'(fill_count), 100);
        rd(99, v);
        check("R6 last entry", v, 16'h0163);
        rd(50, v);
        check("R4 mid entry", v, 16'h0132);

        // R8: saturating drop counter
        do_clear(n);
        send(16'h0001);
        for (int k = 0; k < 300; k++) send(16'h0001);
        check("R8 drop saturates", int'(drop_count), 255);
        check("R8 count", int'(fill_count), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule